// File: doc/BRIEF.md
# Multi-Core Interrupt Claim Controller

This block gathers level-sensitive interrupt requests from a set of devices and hands them out to several processor cores. Each source has its own small state machine that records whether the source is waiting for service or is already being handled. Each core has an enable mask that selects the sources it will accept. Each core also has an interrupt line that rises while at least one source it accepts is waiting.

A core takes a source by pulsing its claim strobe. On that clock edge the controller picks the lowest-numbered waiting source that the core accepts. It latches that source's ID on the core's claim output and moves the source into service, so no other core can take it. When the driver has finished with the device, the core writes the same ID on its completion port, and the source becomes free again.

ID 0 is reserved and means "nothing". With the default of 16 sources, ID 10 is the usual slot for the serial console. A source that no core takes stays waiting for as long as needed, including while every core has masked it. It is delivered as soon as some core unmasks it.

Top module: `ictl_top`

## Requirements
- R1: While reset is asserted, every irq output is 0, every claim ID output is 0, every enable mask is 0 and every source is idle.
- R2: An idle source whose request input is high at a rising clock edge is waiting (pending) after that edge.
- R3: irq of a core is 1 exactly when at least one pending source has its bit set in that core's enable mask. An enable-mask write takes effect at the clock edge where it is strobed.
- R4: A claim strobe at an edge loads the core's claim ID output with the lowest non-zero pending ID enabled for that core, and moves that source to in-service. The claim ID output holds its value until the core's next claim strobe.
- R5: A claim when no enabled source is pending returns 0 and changes no source state.
- R6: When several cores claim at the same edge, the cores are served in ascending core index. A source taken by a lower core is not offered to a higher core, so two cores never receive the same non-zero ID.
- R7: An in-service source does not become pending again while its request stays high, until it is completed.
- R8: A completion write (strobe plus ID) naming an in-service source returns that source to idle at that edge. If its request is still high, it is pending one edge later.
- R9: A completion write with ID 0, or with an ID that is not in service, changes nothing.
- R10: A pending source that nobody claims stays pending for any number of cycles, also while it is masked or its request has dropped. It raises irq again as soon as some core enables it.
- R11: Source 0 never becomes pending. Bit 0 of the request input and of every enable write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Level request per source, bit k = source ID k |
| en_we | input | NUM_CORE | Enable-mask write strobe per core |
| en_wdata | input | NUM_CORE*NUM_SRC | New enable mask, core c in bits [c*NUM_SRC +: NUM_SRC] |
| claim_rd | input | NUM_CORE | Claim strobe per core |
| claim_id | output | NUM_CORE*ID_W | Last claimed ID per core, core c in bits [c*ID_W +: ID_W] |
| cmpl_we | input | NUM_CORE | Completion write strobe per core |
| cmpl_id | input | NUM_CORE*ID_W | Completed source ID per core |
| irq | output | NUM_CORE | External interrupt line per core |

Source states: SRC_IDLE, SRC_PEND, SRC_SERV. The transitions are:
- SRC_IDLE→SRC_PEND on a high request (R2).
- SRC_PEND→SRC_SERV on a grant to any core (R4).
- SRC_SERV→SRC_IDLE on a matching completion (R8).

Every other case holds the current state.

## Verification
The hardest situation to reach is two cores claiming at one edge while their masks overlap. Only this case exercises the exclusion path, where a source taken by the lower core must be withheld from the higher one. The stimulus first sets both masks to the single ID 10 and then issues simultaneous claims, which leaves the upper core with 0. A long random phase then mixes overlapping masks with completions that name random, often stale, IDs, and the behavioural reference model is compared against both outputs on every clock.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_PEND = 2'd1,
        SRC_SERV = 2'd2
    } src_state_e;

endpackage

// File: rtl/ictl_src_fsm.sv
module ictl_src_fsm
    import ictl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic grant,
    input  logic cmpl_hit,
    output logic pend,
    output logic serv
);

    src_state_e st_q;
    src_state_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SRC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SRC_IDLE: if (req)      st_d = SRC_PEND;
            SRC_PEND: if (grant)    st_d = SRC_SERV;
            SRC_SERV: if (cmpl_hit) st_d = SRC_IDLE;
            default:                st_d = SRC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend = 1'b0;
        serv = 1'b0;
        unique case (st_q)
            SRC_PEND: pend = 1'b1;
            SRC_SERV: serv = 1'b1;
            default: begin
                pend = 1'b0;
                serv = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ictl_cmpl_dec.sv
module ictl_cmpl_dec #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_CORE-1:0]      cmpl_we,
    input  logic [NUM_CORE*ID_W-1:0] cmpl_id,
    output logic [NUM_SRC-1:0]       cmpl_hit
);

    always_comb begin
        cmpl_hit = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            for (int k = 1; k < NUM_SRC; k++) begin
                if (cmpl_we[c] && (cmpl_id[c*ID_W +: ID_W] == ID_W'(k))) begin
                    cmpl_hit[k] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ictl_claim_arb.sv
module ictl_claim_arb #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]          pend_vec,
    input  logic [NUM_CORE*NUM_SRC-1:0] en_flat,
    input  logic [NUM_CORE-1:0]         claim_rd,
    output logic [NUM_SRC-1:0]          grant_vec,
    output logic [NUM_CORE*ID_W-1:0]    win_id
);

    logic [NUM_SRC-1:0] taken;
    logic [NUM_SRC-1:0] avail;
    logic [NUM_SRC-1:0] pick;
    logic [ID_W-1:0]    id;

    // cores walked in ascending index; a claiming core removes its pick
    always_comb begin
        taken  = '0;
        avail  = '0;
        pick   = '0;
        id     = '0;
        win_id = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            avail    = pend_vec & en_flat[c*NUM_SRC +: NUM_SRC] & ~taken;
            avail[0] = 1'b0;
            pick     = avail & (~avail + 1'b1);
            id       = '0;
            for (int k = 1; k < NUM_SRC; k++) begin
                if (pick[k]) id = ID_W'(k);
            end
            win_id[c*ID_W +: ID_W] = id;
            if (claim_rd[c]) taken = taken | pick;
        end
        grant_vec = taken;
    end

endmodule

// File: rtl/ictl_core_port.sv
module ictl_core_port #(
    parameter int NUM_SRC = 16,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               claim_rd,
    input  logic [ID_W-1:0]    win_id,
    input  logic [NUM_SRC-1:0] pend_vec,
    output logic [NUM_SRC-1:0] en_q,
    output logic [ID_W-1:0]    claim_q,
    output logic               irq
);

    localparam logic [NUM_SRC-1:0] ID0_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            claim_q <= '0;
        end else begin
            if (en_we)    en_q    <= en_wdata & ID0_MASK;
            if (claim_rd) claim_q <= win_id;
        end
    end

    always_comb begin
        irq = |(pend_vec & en_q);
    end

endmodule

// File: rtl/ictl_top.sv
module ictl_top #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          src_req,
    input  logic [NUM_CORE-1:0]         en_we,
    input  logic [NUM_CORE*NUM_SRC-1:0] en_wdata,
    input  logic [NUM_CORE-1:0]         claim_rd,
    output logic [NUM_CORE*ID_W-1:0]    claim_id,
    input  logic [NUM_CORE-1:0]         cmpl_we,
    input  logic [NUM_CORE*ID_W-1:0]    cmpl_id,
    output logic [NUM_CORE-1:0]         irq
);

    logic [NUM_SRC-1:0]          pend_vec;
    logic [NUM_SRC-1:0]          serv_vec;
    logic [NUM_SRC-1:0]          grant_vec;
    logic [NUM_SRC-1:0]          cmpl_hit;
    logic [NUM_CORE*NUM_SRC-1:0] en_flat;
    logic [NUM_CORE*ID_W-1:0]    win_id;
    logic                        unused_src0;

    assign unused_src0 = src_req[0] ^ grant_vec[0] ^ cmpl_hit[0];

    ictl_cmpl_dec #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_dec (
        .cmpl_we  (cmpl_we),
        .cmpl_id  (cmpl_id),
        .cmpl_hit (cmpl_hit)
    );

    ictl_claim_arb #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_arb (
        .pend_vec  (pend_vec),
        .en_flat   (en_flat),
        .claim_rd  (claim_rd),
        .grant_vec (grant_vec),
        .win_id    (win_id)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        if (k == 0) begin : g_reserved
            assign pend_vec[k] = 1'b0;
            assign serv_vec[k] = 1'b0;
        end else begin : g_fsm
            ictl_src_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (src_req[k]),
                .grant    (grant_vec[k]),
                .cmpl_hit (cmpl_hit[k]),
                .pend     (pend_vec[k]),
                .serv     (serv_vec[k])
            );
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        ictl_core_port #(.NUM_SRC(NUM_SRC)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_we    (en_we[c]),
            .en_wdata (en_wdata[c*NUM_SRC +: NUM_SRC]),
            .claim_rd (claim_rd[c]),
            .win_id   (win_id[c*ID_W +: ID_W]),
            .pend_vec (pend_vec),
            .en_q     (en_flat[c*NUM_SRC +: NUM_SRC]),
            .claim_q  (claim_id[c*ID_W +: ID_W]),
            .irq      (irq[c])
        );
    end

endmodule

// File: rtl/ictl_checker.sv
module ictl_checker #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CORE-1:0]      claim_rd,
    input logic [NUM_CORE*ID_W-1:0] claim_id,
    input logic [NUM_CORE-1:0]      cmpl_we,
    input logic [NUM_CORE*ID_W-1:0] cmpl_id,
    input logic [NUM_CORE-1:0]      irq,
    input logic [NUM_SRC-1:0]       pend_vec,
    input logic [NUM_SRC-1:0]       serv_vec
);

    logic [NUM_SRC-1:0] named;
    always_comb begin
        named = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            if (cmpl_we[c]) named[cmpl_id[c*ID_W +: ID_W]] = 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
        p_empty_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_rd[c] && !irq[c]) |=> (claim_id[c*ID_W +: ID_W] == '0));
        p_claimed_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
            claim_rd[c] |=> ((claim_id[c*ID_W +: ID_W] == '0) ||
                             serv_vec[claim_id[c*ID_W +: ID_W]]));
        for (genvar d = c + 1; d < NUM_CORE; d++) begin : g_d
            p_no_double_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (claim_rd[c] && claim_rd[d]) |=>
                ((claim_id[d*ID_W +: ID_W] == '0) ||
                 (claim_id[c*ID_W +: ID_W] != claim_id[d*ID_W +: ID_W])));
        end
    end

    p_core0_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd[0] && irq[0]) |=> (claim_id[ID_W-1:0] != '0));

    for (genvar k = 1; k < NUM_SRC; k++) begin : g_k
        p_serv_no_repend_r7: assert property (@(posedge clk) disable iff (!rst_n)
            serv_vec[k] |=> !pend_vec[k]);
        p_serv_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(serv_vec[k]) |-> $past(named[k]));
        p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_vec[k]) |-> ($past(|claim_rd) && serv_vec[k]));
    end

endmodule

bind ictl_top ictl_checker #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .claim_rd (claim_rd),
    .claim_id (claim_id),
    .cmpl_we  (cmpl_we),
    .cmpl_id  (cmpl_id),
    .irq      (irq),
    .pend_vec (pend_vec),
    .serv_vec (serv_vec)
);

// File: tb/ictl_top_test.sv
module ictl_top_test;

    localparam int NS = 16;
    localparam int NC = 2;
    localparam int IW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     src_req = '0;
    logic [NC-1:0]     en_we = '0;
    logic [NC*NS-1:0]  en_wdata = '0;
    logic [NC-1:0]     claim_rd = '0;
    logic [NC*IW-1:0]  claim_id;
    logic [NC-1:0]     cmpl_we = '0;
    logic [NC*IW-1:0]  cmpl_id = '0;
    logic [NC-1:0]     irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    ictl_top #(.NUM_SRC(NS), .NUM_CORE(NC)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .en_we(en_we),
        .en_wdata(en_wdata), .claim_rd(claim_rd), .claim_id(claim_id),
        .cmpl_we(cmpl_we), .cmpl_id(cmpl_id), .irq(irq)
    );

    always #10 clk = ~clk;

    // behavioural reference: 0 idle, 1 pending, 2 in service
    int        m_st [NS];
    bit [NS-1:0] m_en [NC];
    int        m_claim [NC];

    initial begin
        for (int k = 0; k < NS; k++) m_st[k] = 0;
        for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_claim[c] = 0; end
    end

    always @(posedge clk) begin
        int nst [NS];
        bit [NS-1:0] took;
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) m_st[k] = 0;
            for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_claim[c] = 0; end
        end else begin
            took = '0;
            for (int c = 0; c < NC; c++) begin
                if (claim_rd[c]) begin
                    int got;
                    got = 0;
                    for (int k = 1; k < NS; k++)
                        if (got == 0 && m_st[k] == 1 && m_en[c][k] && !took[k]) got = k;
                    m_claim[c] = got;
                    if (got != 0) took[got] = 1'b1;
                end
            end
            for (int k = 0; k < NS; k++) begin
                bit done_k;
                done_k = 0;
                for (int c = 0; c < NC; c++)
                    if (cmpl_we[c] && int'(cmpl_id[c*IW +: IW]) == k) done_k = 1;
                nst[k] = m_st[k];
                if (m_st[k] == 1 && took[k]) nst[k] = 2;
                else if (m_st[k] == 2 && done_k) nst[k] = 0;
                else if (m_st[k] == 0 && src_req[k] && k != 0) nst[k] = 1;
            end
            for (int k = 0; k < NS; k++) m_st[k] = nst[k];
            for (int c = 0; c < NC; c++)
                if (en_we[c]) m_en[c] = en_wdata[c*NS +: NS] & ~NS'(1);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #5;
        if (!done) begin
            for (int c = 0; c < NC; c++) begin
                bit exp_irq;
                exp_irq = 0;
                for (int k = 1; k < NS; k++) if (m_st[k] == 1 && m_en[c][k]) exp_irq = 1;
                check(irq[c] == exp_irq, "R3 irq vs model", int'(irq[c]), int'(exp_irq));
                check(int'(claim_id[c*IW +: IW]) == m_claim[c], "R4 claim_id vs model",
                      int'(claim_id[c*IW +: IW]), m_claim[c]);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int cid(input int c);
        return int'(claim_id[c*IW +: IW]);
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        src_req = 16'h0020;
        cyc(3);
        check(irq == 0, "R1 irq in reset", int'(irq), 0);
        check(claim_id == 0, "R1 claim in reset", int'(claim_id), 0);
        src_req = '0;
        rst_n = 1'b1;
        cyc(1);
        check(irq == 0, "R1 nothing pending after reset", int'(irq), 0);

        en_we = 2'b11; en_wdata = {16'h0400, 16'hFFFF};
        cyc(1);
        en_we = '0;
        check(irq == 0, "R3 enabled but idle", int'(irq), 0);

        src_req = 16'h0409;
        cyc(1);
        check(irq == 2'b11, "R2 pending one edge after request", int'(irq), 3);

        claim_rd = 2'b11;
        cyc(1);
        claim_rd = '0;
        check(cid(0) == 3, "R4 lowest enabled id, R11 id0 skipped", cid(0), 3);
        check(cid(1) == 10, "R6 second core gets other source", cid(1), 10);
        check(irq == 0, "R7 in service drops irq", int'(irq), 0);
        cyc(5);
        check(irq == 0, "R7 no re-raise while request high", int'(irq), 0);
        check(cid(0) == 3, "R4 claim id holds", cid(0), 3);

        claim_rd = 2'b01;
        cyc(1);
        claim_rd = '0;
        check(cid(0) == 0, "R5 empty claim returns 0", cid(0), 0);

        cmpl_we = 2'b11; cmpl_id = {4'd0, 4'd5};
        cyc(1);
        cmpl_we = '0;
        cyc(2);
        check(irq == 0, "R9 bad completion ignored", int'(irq), 0);

        cmpl_we = 2'b01; cmpl_id = {4'd0, 4'd3};
        cyc(1);
        cmpl_we = '0;
        check(irq[0] == 0, "R8 idle at completion edge", int'(irq[0]), 0);
        cyc(1);
        check(irq[0] == 1, "R8 re-pend one edge later", int'(irq[0]), 1);

        src_req = 16'h0401;
        en_we = 2'b01; en_wdata = {16'h0400, 16'h0000};
        cyc(1);
        en_we = '0;
        check(irq[0] == 0, "R10 masked source hidden", int'(irq[0]), 0);
        cyc(20);
        en_we = 2'b01; en_wdata = {16'h0400, 16'hFFFF};
        cyc(1);
        en_we = '0;
        check(irq[0] == 1, "R10 delivered after unmask", int'(irq[0]), 1);
        claim_rd = 2'b01;
        cyc(1);
        claim_rd = '0;
        check(cid(0) == 3, "R10 held source claimed", cid(0), 3);

        cmpl_we = 2'b11; cmpl_id = {4'd10, 4'd3};
        en_we = 2'b11; en_wdata = {16'h0400, 16'h0400};
        cyc(1);
        cmpl_we = '0; en_we = '0;
        cyc(1);
        claim_rd = 2'b11;
        cyc(1);
        claim_rd = '0;
        check(cid(0) == 10, "R6 lower core wins shared source", cid(0), 10);
        check(cid(1) == 0, "R6 upper core gets 0", cid(1), 0);

        for (int i = 0; i < 3000; i++) begin
            src_req  = NS'($urandom);
            claim_rd = NC'($urandom_range(0, 3));
            cmpl_we  = NC'($urandom_range(0, 3));
            cmpl_id  = {IW'($urandom), IW'($urandom)};
            if ($urandom_range(0, 15) == 0) begin
                en_we    = NC'($urandom_range(1, 3));
                en_wdata = {NS'($urandom), NS'($urandom)};
            end else begin
                en_we = '0;
            end
            cyc(1);
        end
        src_req = '0; claim_rd = '0; cmpl_we = '0; en_we = '0;
        cyc(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule